// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Vectoring

This block gathers every interrupt request that can reach a small processor core and, at each instruction boundary the core signals, picks the single request to service. Peripheral requests come in as pairs of a status flag and an enable bit. Several pairs may feed one shared interrupt number; the four pairs of the serial port are one example. A level-sensitive maskable line, an edge-captured non-maskable line, a software trap and an illegal-opcode trap are also accepted. The core's two mask bits are inputs: `i_mask` gates the maskable requests and `x_mask` gates the non-maskable line.

On an instruction boundary with something to service, the block reports the chosen interrupt number, the address of its 16-bit vector, which mask bit the core must set, and the extra cycle cost of the entry sequence. It does not push the stack, read the vector or model the core. Among the maskable sources, the order of service comes from a table that software can rewrite. The table returns to identity order on reset.

Top module: `intr_arbiter`

## Requirements
- R1: A peripheral pair counts as pending only while its flag and its enable are both 1. Pair p (p >= 4) maps to interrupt number p-2, so pair 4 maps to 2 and pair 15 maps to 13.
- R2: Pairs 0 to 3 share interrupt number 1. That number stays pending while any one of the four pairs has flag and enable set.
- R3: The software trap (number 30) beats every other source, ignores `i_mask` and `x_mask`, and its pending bit clears in the cycle it is taken.
- R4: The illegal-opcode trap (number 31) comes second, is unmaskable, and its pending bit clears when taken.
- R5: The captured non-maskable request (number 29) is taken only while `x_mask` is 0, and its pending bit then clears. While it is pending and `x_mask` is 1, no source below it is selected.
- R6: While `i_mask` is 1, neither the maskable line (number 28) nor any peripheral is selected.
- R7: Maskable sources are served in the order of a table of 32 slots, with slot 0 first. After reset, slot k holds number k. Writing `ord_id` into slot `ord_slot` with `ord_wr` changes the order from the next cycle on.
- R8: Peripheral and maskable-line pending bits follow their inputs and are not cleared by being taken, so an uncleared source is taken again at the next boundary.
- R9: The vector address is 0xFFC0 + 2*number when `boot_mode` is 0, and 0xBFC0 + 2*number when it is 1.
- R10: When number 29 is taken, `set_x` pulses and `set_i` stays 0. For any other taken number, `set_i` pulses and `set_x` stays 0.
- R11: `svc_cycles` reads 14 while `take_valid` is high and 0 otherwise.
- R12: `take_valid` is high for exactly one cycle after each clock edge that sees `insn_boundary` high with a source selectable. Reset clears all pending bits and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode | input | 1 | 1 selects the bootstrap vector base |
| src_flag | input | 16 | Peripheral status flags, one per pair |
| src_en | input | 16 | Peripheral enable bits, one per pair |
| irq_lvl | input | 1 | Level-sensitive maskable request |
| swi_req | input | 1 | Software trap request pulse |
| ill_req | input | 1 | Illegal-opcode trap request pulse |
| xirq_req | input | 1 | Non-maskable request pulse, captured until taken |
| i_mask | input | 1 | Core mask bit for maskable sources |
| x_mask | input | 1 | Core mask bit for the non-maskable line |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| ord_wr | input | 1 | Write strobe for the order table |
| ord_slot | input | 5 | Order-table slot to write |
| ord_id | input | 5 | Interrupt number to store in the slot |
| take_valid | output | 1 | One-cycle strobe: an interrupt is taken |
| take_id | output | 5 | Interrupt number taken |
| take_vec | output | 16 | Address of the vector word |
| set_x | output | 1 | Core must set its non-maskable mask bit |
| set_i | output | 1 | Core must set its maskable mask bit |
| svc_cycles | output | 4 | Extra cycles charged for the entry |

## Verification
A flag, enable or request pulse is captured into the pending bits at the first rising edge that sees it. The selection that follows is registered at the next rising edge that sees `insn_boundary` high, so the outputs appear two edges after the stimulus and one edge after the boundary. The bench drives every input on the falling edge. It raises `insn_boundary` one falling edge after the stimulus and reads the outputs on the next falling edge, halfway between rising edges. Self-clearing and re-firing are checked by holding the boundary for a second cycle and reading the following falling edge, when the pending state left by the first take has taken effect.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int NUM_INT       = 32;
  localparam int ID_W          = $clog2(NUM_INT);
  localparam int NUM_PAIRS     = 16;
  localparam int SHARED_PAIRS  = 4;
  localparam int SHARED_ID     = 1;
  localparam int FIRST_SOLO_ID = 2;
  localparam int IRQ_ID        = 28;
  localparam int XIRQ_ID       = 29;
  localparam int SWI_ID        = 30;
  localparam int ILL_ID        = 31;
  localparam int VEC_W         = 16;
  localparam int SVC_CYCLES    = 14;
  localparam int SVC_W         = $clog2(SVC_CYCLES + 1);
  localparam logic [VEC_W-1:0] NORMAL_BASE = 16'hFFC0;
  localparam logic [VEC_W-1:0] BOOT_BASE   = 16'hBFC0;

  typedef logic [ID_W-1:0] int_id_t;

  // Interrupt number fed by a flag/enable pair
  function automatic int_id_t pair_target(input int p);
    if (p < SHARED_PAIRS) return int_id_t'(SHARED_ID);
    return int_id_t'(FIRST_SOLO_ID + p - SHARED_PAIRS);
  endfunction

  // Vector word address for a number under the given mode
  function automatic logic [VEC_W-1:0] vector_of(input logic boot, input int_id_t id);
    logic [VEC_W-1:0] base;
    base = boot ? BOOT_BASE : NORMAL_BASE;
    return base + {{(VEC_W-ID_W-1){1'b0}}, id, 1'b0};
  endfunction
endpackage

// File: rtl/intr_pend_reg.sv
module intr_pend_reg
  import intr_arb_pkg::*;
#(
  parameter int N = NUM_INT,
  parameter int P = NUM_PAIRS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] flag,
  input  logic [P-1:0] en,
  input  logic         irq_lvl,
  input  logic         swi_req,
  input  logic         ill_req,
  input  logic         xirq_req,
  input  logic         clr_swi,
  input  logic         clr_ill,
  input  logic         clr_xirq,
  output logic [N-1:0] pend
);
  logic [N-1:0] lvl;
  logic [N-1:0] pend_nx;

  // OR all active pairs into their numbers; an inactive pair never sets
  always_comb begin
    lvl = '0;
    for (int p = 0; p < P; p++) begin
      if (flag[p] && en[p]) lvl[pair_target(p)] = 1'b1;
    end
  end

  always_comb begin
    pend_nx          = lvl;
    pend_nx[IRQ_ID]  = irq_lvl;
    pend_nx[SWI_ID]  = (pend[SWI_ID]  & ~clr_swi)  | swi_req;
    pend_nx[ILL_ID]  = (pend[ILL_ID]  & ~clr_ill)  | ill_req;
    pend_nx[XIRQ_ID] = (pend[XIRQ_ID] & ~clr_xirq) | xirq_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nx;
  end

  // R1: a solo number is pending only if its pair was active the cycle before
  for (genvar g = SHARED_PAIRS; g < P; g++) begin : g_solo_chk
    localparam int TGT = pair_target(g);
    solo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[TGT] |-> $past(flag[g] && en[g]));
  end

  // R2
  shared_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[SHARED_ID] |-> $past(|(flag[SHARED_PAIRS-1:0] & en[SHARED_PAIRS-1:0])));

  // R3
  swi_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_swi) && !$past(swi_req)) |-> !pend[SWI_ID]);

  // R4
  ill_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_ill) && !$past(ill_req)) |-> !pend[ILL_ID]);
endmodule

// File: rtl/intr_order_scan.sv
module intr_order_scan
  import intr_arb_pkg::*;
#(
  parameter int N  = NUM_INT,
  parameter int IW = ID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] wr_slot,
  input  logic [IW-1:0] wr_id,
  input  logic [N-1:0]  cand,
  output logic          hit,
  output logic [IW-1:0] hit_id
);
  logic [IW-1:0] tbl [N];

  for (genvar s = 0; s < N; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                         tbl[s] <= IW'(s);
      else if (wr && wr_slot == IW'(s))   tbl[s] <= wr_id;
    end
  end

  // Walk from the last slot down so the lowest matching slot is kept
  always_comb begin
    hit    = 1'b0;
    hit_id = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (cand[tbl[s]]) begin
        hit    = 1'b1;
        hit_id = tbl[s];
      end
    end
  end

  // R7
  scan_hit_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cand[hit_id]);
endmodule

// File: rtl/intr_pick.sv
module intr_pick
  import intr_arb_pkg::*;
#(
  parameter int N  = NUM_INT,
  parameter int IW = ID_W
) (
  input  logic [N-1:0]  pend,
  input  logic          i_mask,
  input  logic          x_mask,
  input  logic          scan_hit,
  input  logic [IW-1:0] scan_id,
  output logic          sel_valid,
  output logic [IW-1:0] sel_id,
  output logic          xirq_blocked
);
  always_comb begin
    sel_valid    = 1'b0;
    sel_id       = '0;
    xirq_blocked = 1'b0;
    if (pend[SWI_ID]) begin
      sel_valid = 1'b1;
      sel_id    = IW'(SWI_ID);
    end else if (pend[ILL_ID]) begin
      sel_valid = 1'b1;
      sel_id    = IW'(ILL_ID);
    end else if (pend[XIRQ_ID]) begin
      if (!x_mask) begin
        sel_valid = 1'b1;
        sel_id    = IW'(XIRQ_ID);
      end else begin
        xirq_blocked = 1'b1;
      end
    end else if (!i_mask && scan_hit) begin
      sel_valid = 1'b1;
      sel_id    = scan_id;
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_arb_pkg::*;
#(
  parameter int N  = NUM_INT,
  parameter int P  = NUM_PAIRS,
  parameter int IW = ID_W,
  parameter int VW = VEC_W,
  parameter int CW = SVC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_mode,
  input  logic [P-1:0]  src_flag,
  input  logic [P-1:0]  src_en,
  input  logic          irq_lvl,
  input  logic          swi_req,
  input  logic          ill_req,
  input  logic          xirq_req,
  input  logic          i_mask,
  input  logic          x_mask,
  input  logic          insn_boundary,
  input  logic          ord_wr,
  input  logic [IW-1:0] ord_slot,
  input  logic [IW-1:0] ord_id,
  output logic          take_valid,
  output logic [IW-1:0] take_id,
  output logic [VW-1:0] take_vec,
  output logic          set_x,
  output logic          set_i,
  output logic [CW-1:0] svc_cycles
);
  localparam logic [N-1:0] TRAP_BITS =
    (N'(1) << SWI_ID) | (N'(1) << ILL_ID) | (N'(1) << XIRQ_ID);

  logic [N-1:0]  pend;
  logic [N-1:0]  cand;
  logic          scan_hit;
  logic [IW-1:0] scan_id;
  logic          sel_valid;
  logic [IW-1:0] sel_id;
  logic          xirq_blocked;
  logic          take_now;
  logic          clr_swi, clr_ill, clr_xirq;

  assign take_now = insn_boundary && sel_valid;
  assign clr_swi  = take_now && (sel_id == IW'(SWI_ID));
  assign clr_ill  = take_now && (sel_id == IW'(ILL_ID));
  assign clr_xirq = take_now && (sel_id == IW'(XIRQ_ID));
  assign cand     = pend & ~TRAP_BITS;

  intr_pend_reg #(.N(N), .P(P)) u_pend (
    .clk(clk), .rst_n(rst_n), .flag(src_flag), .en(src_en),
    .irq_lvl(irq_lvl), .swi_req(swi_req), .ill_req(ill_req),
    .xirq_req(xirq_req), .clr_swi(clr_swi), .clr_ill(clr_ill),
    .clr_xirq(clr_xirq), .pend(pend)
  );

  intr_order_scan #(.N(N), .IW(IW)) u_scan (
    .clk(clk), .rst_n(rst_n), .wr(ord_wr), .wr_slot(ord_slot),
    .wr_id(ord_id), .cand(cand), .hit(scan_hit), .hit_id(scan_id)
  );

  intr_pick #(.N(N), .IW(IW)) u_pick (
    .pend(pend), .i_mask(i_mask), .x_mask(x_mask),
    .scan_hit(scan_hit), .scan_id(scan_id),
    .sel_valid(sel_valid), .sel_id(sel_id), .xirq_blocked(xirq_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_valid <= 1'b0;
      take_id    <= '0;
      take_vec   <= '0;
      set_x      <= 1'b0;
      set_i      <= 1'b0;
      svc_cycles <= '0;
    end else begin
      take_valid <= take_now;
      take_id    <= take_now ? sel_id : '0;
      take_vec   <= take_now ? vector_of(boot_mode, sel_id) : '0;
      set_x      <= take_now && (sel_id == IW'(XIRQ_ID));
      set_i      <= take_now && (sel_id != IW'(XIRQ_ID));
      svc_cycles <= take_now ? CW'(SVC_CYCLES) : '0;
    end
  end

  // R12
  valid_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> $past(insn_boundary));

  // R5
  xirq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_x |-> $past(!x_mask));

  // R5
  xirq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xirq_blocked && insn_boundary) |=> !take_valid);

  // R6
  imask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && set_i && take_id != IW'(SWI_ID) && take_id != IW'(ILL_ID))
      |-> $past(!i_mask));

  // R9
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (take_vec[VW-1:6] == NORMAL_BASE[VW-1:6] ||
                    take_vec[VW-1:6] == BOOT_BASE[VW-1:6]));

  // R10
  one_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> $onehot({set_x, set_i}));

  // R11
  cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |-> (svc_cycles == '0 && !set_x && !set_i));
endmodule

// File: tb/intr_arbiter_tb.sv
module intr_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_mode = 1'b0;
  logic [15:0] src_flag = '0;
  logic [15:0] src_en = '0;
  logic        irq_lvl = 1'b0, swi_req = 1'b0, ill_req = 1'b0, xirq_req = 1'b0;
  logic        i_mask = 1'b0, x_mask = 1'b0, insn_boundary = 1'b0;
  logic        ord_wr = 1'b0;
  logic [4:0]  ord_slot = '0, ord_id = '0;
  logic        take_valid, set_x, set_i;
  logic [4:0]  take_id;
  logic [15:0] take_vec;
  logic [3:0]  svc_cycles;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  intr_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .src_flag(src_flag),
    .src_en(src_en), .irq_lvl(irq_lvl), .swi_req(swi_req), .ill_req(ill_req),
    .xirq_req(xirq_req), .i_mask(i_mask), .x_mask(x_mask),
    .insn_boundary(insn_boundary), .ord_wr(ord_wr), .ord_slot(ord_slot),
    .ord_id(ord_id), .take_valid(take_valid), .take_id(take_id),
    .take_vec(take_vec), .set_x(set_x), .set_i(set_i), .svc_cycles(svc_cycles)
  );

  typedef struct packed {
    logic [15:0] flg;
    logic [15:0] en;
    logic sw, il, xq, iq, im, xm, bt, ev;
    logic [4:0] eid;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 5'd0},
    '{16'h0010, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 5'd0},
    '{16'h0010, 16'h0010, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 5'd2},
    '{16'h0001, 16'h0010, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 5'd0},
    '{16'h0004, 16'h0004, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 5'd1},
    '{16'h0009, 16'h0009, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 5'd1},
    '{16'h0030, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 5'd2},
    '{16'h0010, 16'h0010, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0, 5'd0},
    '{16'h0000, 16'h0000, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1, 5'd30},
    '{16'h0010, 16'h0010, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1, 5'd31},
    '{16'h0000, 16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 5'd30},
    '{16'h0010, 16'h0010, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 5'd29},
    '{16'h0010, 16'h0010, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0, 5'd0},
    '{16'h0000, 16'h0000, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1, 5'd31},
    '{16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1, 5'd28},
    '{16'h0010, 16'h0010, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1, 5'd2},
    '{16'h0010, 16'h0010, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1, 5'd2},
    '{16'h8000, 16'h8000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 5'd13},
    '{16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0, 5'd0}
  };
  localparam string TAGS [NV] = '{
    "R12", "R1", "R1", "R1", "R2", "R2", "R7", "R6", "R3", "R4",
    "R3", "R5", "R5", "R4", "R10", "R7", "R9", "R1", "R6"
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // Compare every output against a result derived from number, mode and validity
  task automatic expect_take(input string req, input logic ev,
                             input logic [4:0] eid, input logic bt);
    logic [15:0] ev_vec;
    ev_vec = ev ? ((bt ? 16'hBFC0 : 16'hFFC0) + 16'(eid) * 16'd2) : 16'h0000;
    check(req, "take_valid", 32'(take_valid), 32'(ev));
    check(req, "take_id", 32'(take_id), ev ? 32'(eid) : 32'd0);
    check(req, "take_vec", 32'(take_vec), 32'(ev_vec));
    check("R10", "set_x", 32'(set_x), 32'(ev && eid == 5'd29));
    check("R10", "set_i", 32'(set_i), 32'(ev && eid != 5'd29));
    check("R11", "svc_cycles", 32'(svc_cycles), ev ? 32'd14 : 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_flag = '0; src_en = '0; irq_lvl = 1'b0;
    swi_req = 1'b0; ill_req = 1'b0; xirq_req = 1'b0;
    i_mask = 1'b0; x_mask = 1'b0; boot_mode = 1'b0;
    insn_boundary = 1'b0; ord_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Stimulus at one falling edge, boundary at the next, sample at the one after
  task automatic pulse_boundary();
    @(negedge clk);
    swi_req = 1'b0; ill_req = 1'b0; xirq_req = 1'b0;
    insn_boundary = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_order(input logic [4:0] slot, input logic [4:0] id);
    @(negedge clk);
    ord_wr = 1'b1; ord_slot = slot; ord_id = id;
    @(negedge clk);
    ord_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL R12 watchdog actual=%0d expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset state (R12)
    @(negedge clk);
    @(negedge clk);
    expect_take("R12", 1'b0, 5'd0, 1'b0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      src_flag = TBL[v].flg; src_en = TBL[v].en;
      swi_req = TBL[v].sw; ill_req = TBL[v].il; xirq_req = TBL[v].xq;
      irq_lvl = TBL[v].iq; i_mask = TBL[v].im; x_mask = TBL[v].xm;
      boot_mode = TBL[v].bt;
      pulse_boundary();
      expect_take(TAGS[v], TBL[v].ev, TBL[v].eid, TBL[v].bt);
      insn_boundary = 1'b0;
    end

    // R8: level source re-fires on consecutive boundaries, then stops once cleared
    do_reset();
    src_flag = 16'h0010; src_en = 16'h0010;
    pulse_boundary();
    expect_take("R8", 1'b1, 5'd2, 1'b0);
    @(negedge clk);
    expect_take("R8", 1'b1, 5'd2, 1'b0);
    insn_boundary = 1'b0;
    src_flag = 16'h0000;
    pulse_boundary();
    expect_take("R8", 1'b0, 5'd0, 1'b0);
    insn_boundary = 1'b0;

    // R3: software trap self-clears after one take
    do_reset();
    i_mask = 1'b1; swi_req = 1'b1;
    pulse_boundary();
    expect_take("R3", 1'b1, 5'd30, 1'b0);
    @(negedge clk);
    expect_take("R3", 1'b0, 5'd0, 1'b0);
    insn_boundary = 1'b0;

    // R5: non-maskable request self-clears after one take
    do_reset();
    i_mask = 1'b1; xirq_req = 1'b1;
    pulse_boundary();
    expect_take("R5", 1'b1, 5'd29, 1'b0);
    @(negedge clk);
    expect_take("R5", 1'b0, 5'd0, 1'b0);
    insn_boundary = 1'b0;

    // R12: nothing without a boundary; one strobe per boundary cycle
    do_reset();
    src_flag = 16'h0010; src_en = 16'h0010;
    repeat (3) @(negedge clk);
    expect_take("R12", 1'b0, 5'd0, 1'b0);
    pulse_boundary();
    insn_boundary = 1'b0;
    expect_take("R12", 1'b1, 5'd2, 1'b0);
    @(negedge clk);
    expect_take("R12", 1'b0, 5'd0, 1'b0);

    // R12: reset discards a captured, blocked non-maskable request
    do_reset();
    x_mask = 1'b1; xirq_req = 1'b1;
    @(negedge clk);
    xirq_req = 1'b0;
    do_reset();
    pulse_boundary();
    expect_take("R12", 1'b0, 5'd0, 1'b0);
    insn_boundary = 1'b0;

    // R7: rewritten order table, then identity order back after reset
    do_reset();
    write_order(5'd0, 5'd13);
    src_flag = 16'h8010; src_en = 16'h8010;
    pulse_boundary();
    expect_take("R7", 1'b1, 5'd13, 1'b0);
    insn_boundary = 1'b0;
    write_order(5'd0, 5'd3);
    src_flag = 16'h0030; src_en = 16'h0030;
    pulse_boundary();
    expect_take("R7", 1'b1, 5'd3, 1'b0);
    insn_boundary = 1'b0;
    do_reset();
    src_flag = 16'h0030; src_en = 16'h0030;
    pulse_boundary();
    expect_take("R7", 1'b1, 5'd2, 1'b0);
    insn_boundary = 1'b0;

    // R9: bootstrap base with a high number
    do_reset();
    boot_mode = 1'b1; ill_req = 1'b1;
    pulse_boundary();
    expect_take("R9", 1'b1, 5'd31, 1'b1);
    insn_boundary = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule